// File: doc/BRIEF.md
# Predicated Execution Slice with Deferred-Fault Tokens

This block is the execute-and-retire slice of a single-issue core that runs predicated code. Each cycle it may take one already decoded instruction: a 4-bit opcode, a destination register, two source registers, two destination predicate indices, a 64-bit immediate and the index of the predicate that qualifies the instruction. The slice holds a file of 64 one-bit predicates and a file of 128 general registers. Each general register carries 64 data bits plus a poison bit. The poison bit marks a fault that was deferred.

Compares write a complementary pair of predicates. Any instruction whose qualifying predicate reads false retires with no effect. Load data and a load fault flag come in as plain inputs, since the slice does not model memory. A speculative load that faults does not trap. It leaves a poisoned destination instead, and ordinary operations carry the poison forward into their results. A later check instruction tests a register for poison and, if it finds it, pulses a redirect toward a fix-up address taken from the immediate. Two combinational peek ports let the surrounding logic read any general register and any predicate.

Top module: `pred_exec_core`

## Requirements
- R1: Predicate 0 always reads 1 and general register 0 always reads data 0 with poison 0. Writes aimed at either are discarded.
- R2: An instruction with `instr_valid_i` high whose qualifying predicate (`qp_i`) reads 0 changes no register or predicate and raises neither `exc_o` nor `redirect_o`.
- R3: Compares are opcodes 6 (equal) and 7 (not equal). With both sources clean, the predicate at `pdst_a_i` receives the result and the predicate at `pdst_b_i` receives its inverse. If either source is poisoned, both receive 0. When the two indices are equal, the `pdst_a_i` value is kept.
- R4: The arithmetic and logic opcodes are 1 (rs1+rs2), 2 (rs1-rs2), 3 (rs1 AND rs2), 4 (rs1 XOR rs2) and 5 (rs1+imm). Each writes its 64-bit result to `rd_i`. The destination poison is the OR of the poison bits of the sources the opcode reads.
- R5: A successful load writes `ld_data_i` with poison 0. The load opcodes are 8 (ordinary) and 9 (speculative), and a load succeeds when `ld_fault_i` is 0.
- R6: A speculative load (opcode 9) with `ld_fault_i` high writes data 0 with poison 1 to `rd_i` and leaves `exc_o` low.
- R7: An ordinary load (opcode 8) with `ld_fault_i` high leaves `rd_i` unchanged and drives `exc_o` high for exactly the following cycle.
- R8: A check (opcode 10) on a poisoned `rs1_i` drives `redirect_o` high for the following cycle, with `redirect_target_o` equal to the immediate. On a clean register it does nothing. Opcodes 0 and 11 to 15 do nothing.
- R9: After reset, every general register reads 0 with poison 0, every predicate other than predicate 0 reads 0, and `exc_o` and `redirect_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 4 | Opcode |
| qp_i | input | 6 | Qualifying predicate index |
| rd_i | input | 7 | Destination general register |
| rs1_i | input | 7 | First source register |
| rs2_i | input | 7 | Second source register |
| pdst_a_i | input | 6 | Compare destination for the result |
| pdst_b_i | input | 6 | Compare destination for the inverse |
| imm_i | input | 64 | Immediate operand and fix-up address |
| ld_data_i | input | 64 | Load return data |
| ld_fault_i | input | 1 | The load would fault |
| exc_o | output | 1 | Fault from an ordinary load, one cycle |
| redirect_o | output | 1 | Fix-up redirect from a check, one cycle |
| redirect_target_o | output | 64 | Fix-up address |
| gr_peek_addr_i | input | 7 | General register peek index |
| gr_peek_data_o | output | 64 | Peeked register data |
| gr_peek_nat_o | output | 1 | Peeked register poison bit |
| pr_peek_addr_i | input | 6 | Predicate peek index |
| pr_peek_val_o | output | 1 | Peeked predicate value |

## Verification
Register and predicate writes take effect at the clock edge that samples the instruction, and the peek ports are combinational, so new contents can be read shortly after that edge. `exc_o`, `redirect_o` and the target are registered on that same edge and hold for one cycle. The bench therefore drives each instruction between edges, waits for one rising edge, drops `instr_valid_i` and samples all results a few nanoseconds after that edge, before the next one. It compares them with a reference model that it updated when the instruction was issued.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_XOR   = 4'd4,
        OP_ADDI  = 4'd5,
        OP_CMPEQ = 4'd6,
        OP_CMPNE = 4'd7,
        OP_LD    = 4'd8,
        OP_LDS   = 4'd9,
        OP_CHKS  = 4'd10
    } pec_op_e;

endpackage

// File: rtl/pec_gregfile.sv
module pec_gregfile #(
    parameter int XLEN = 64,
    parameter int NREG = 128,
    parameter int AW   = $clog2(NREG),
    parameter int NRD  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic                      wnat,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata,
    output logic [NRD-1:0]            rnat
);

    logic [XLEN-1:0] data_q [NREG];
    logic [NREG-1:0] nat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                data_q[i] <= '0;
            end
            nat_q <= '0;
        end else if (we && (waddr != '0)) begin
            data_q[waddr] <= wdata;
            nat_q[waddr]  <= wnat;
        end
    end

    // register 0 is hard-wired to a clean zero
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0   : data_q[raddr[g]];
        assign rnat[g]  = (raddr[g] == '0) ? 1'b0 : nat_q[raddr[g]];
    end

endmodule

// File: rtl/pec_predfile.sv
module pec_predfile #(
    parameter int NPRED = 64,
    parameter int PW    = $clog2(NPRED),
    parameter int NRD   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PW-1:0]          waddr_a,
    input  logic                   wval_a,
    input  logic [PW-1:0]          waddr_b,
    input  logic                   wval_b,
    input  logic [NRD-1:0][PW-1:0] raddr,
    output logic [NRD-1:0]         rval
);

    logic [NPRED-1:0] pr_q;

    // port a is written last so it wins when both indices match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= '0;
        end else if (we) begin
            if (waddr_b != '0) pr_q[waddr_b] <= wval_b;
            if (waddr_a != '0) pr_q[waddr_a] <= wval_a;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rval[g] = (raddr[g] == '0) ? 1'b1 : pr_q[raddr[g]];
    end

endmodule

// File: rtl/pec_exec.sv
module pec_exec
    import pec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            en,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic            nat_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            nat_b,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] ld_data,
    input  logic            ld_fault,
    output logic            gr_we,
    output logic [XLEN-1:0] gr_wdata,
    output logic            gr_wnat,
    output logic            pr_we,
    output logic            pr_val_a,
    output logic            pr_val_b,
    output logic            exc,
    output logic            redir
);

    pec_op_e op_e;
    logic    cmp_res;

    assign op_e = pec_op_e'(op);

    always_comb begin
        gr_we    = 1'b0;
        gr_wdata = '0;
        gr_wnat  = 1'b0;
        pr_we    = 1'b0;
        pr_val_a = 1'b0;
        pr_val_b = 1'b0;
        exc      = 1'b0;
        redir    = 1'b0;
        cmp_res  = (op_e == OP_CMPEQ) ? (src_a == src_b) : (src_a != src_b);
        if (en) begin
            case (op_e)
                OP_ADD:  begin gr_we = 1'b1; gr_wdata = src_a + src_b; gr_wnat = nat_a | nat_b; end
                OP_SUB:  begin gr_we = 1'b1; gr_wdata = src_a - src_b; gr_wnat = nat_a | nat_b; end
                OP_AND:  begin gr_we = 1'b1; gr_wdata = src_a & src_b; gr_wnat = nat_a | nat_b; end
                OP_XOR:  begin gr_we = 1'b1; gr_wdata = src_a ^ src_b; gr_wnat = nat_a | nat_b; end
                OP_ADDI: begin gr_we = 1'b1; gr_wdata = src_a + imm;   gr_wnat = nat_a; end
                OP_CMPEQ, OP_CMPNE: begin
                    pr_we = 1'b1;
                    if (!(nat_a || nat_b)) begin
                        pr_val_a = cmp_res;
                        pr_val_b = !cmp_res;
                    end
                end
                OP_LD: begin
                    if (ld_fault) exc = 1'b1;
                    else begin gr_we = 1'b1; gr_wdata = ld_data; end
                end
                OP_LDS: begin
                    gr_we = 1'b1;
                    if (ld_fault) gr_wnat  = 1'b1;
                    else          gr_wdata = ld_data;
                end
                OP_CHKS: redir = nat_a;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pred_exec_core.sv
module pred_exec_core #(
    parameter int XLEN  = 64,
    parameter int NGR   = 128,
    parameter int NPRED = 64,
    parameter int GW    = $clog2(NGR),
    parameter int PW    = $clog2(NPRED)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid_i,
    input  logic [3:0]      op_i,
    input  logic [PW-1:0]   qp_i,
    input  logic [GW-1:0]   rd_i,
    input  logic [GW-1:0]   rs1_i,
    input  logic [GW-1:0]   rs2_i,
    input  logic [PW-1:0]   pdst_a_i,
    input  logic [PW-1:0]   pdst_b_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] ld_data_i,
    input  logic            ld_fault_i,
    output logic            exc_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_target_o,
    input  logic [GW-1:0]   gr_peek_addr_i,
    output logic [XLEN-1:0] gr_peek_data_o,
    output logic            gr_peek_nat_o,
    input  logic [PW-1:0]   pr_peek_addr_i,
    output logic            pr_peek_val_o
);

    localparam int GR_PORTS = 3;
    localparam int PR_PORTS = 2;

    typedef struct packed {
        logic            exc;
        logic            redir;
        logic [XLEN-1:0] target;
    } out_t;

    out_t out_d, out_q;

    logic [GR_PORTS-1:0][GW-1:0]   gr_raddr;
    logic [GR_PORTS-1:0][XLEN-1:0] gr_rdata;
    logic [GR_PORTS-1:0]           gr_rnat;
    logic [PR_PORTS-1:0][PW-1:0]   pr_raddr;
    logic [PR_PORTS-1:0]           pr_rval;

    logic            qp_true;
    logic            fire;
    logic            ex_gr_we, ex_gr_wnat, ex_pr_we, ex_pa, ex_pb, ex_exc, ex_redir;
    logic [XLEN-1:0] ex_gr_wdata;

    assign gr_raddr = {gr_peek_addr_i, rs2_i, rs1_i};
    assign pr_raddr = {pr_peek_addr_i, qp_i};
    assign qp_true  = pr_rval[0];
    assign fire     = instr_valid_i & qp_true;

    pec_gregfile #(.XLEN(XLEN), .NREG(NGR), .AW(GW), .NRD(GR_PORTS)) u_gr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ex_gr_we),
        .waddr (rd_i),
        .wdata (ex_gr_wdata),
        .wnat  (ex_gr_wnat),
        .raddr (gr_raddr),
        .rdata (gr_rdata),
        .rnat  (gr_rnat)
    );

    pec_predfile #(.NPRED(NPRED), .PW(PW), .NRD(PR_PORTS)) u_pr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ex_pr_we),
        .waddr_a (pdst_a_i),
        .wval_a  (ex_pa),
        .waddr_b (pdst_b_i),
        .wval_b  (ex_pb),
        .raddr   (pr_raddr),
        .rval    (pr_rval)
    );

    pec_exec #(.XLEN(XLEN)) u_ex (
        .en       (fire),
        .op       (op_i),
        .src_a    (gr_rdata[0]),
        .nat_a    (gr_rnat[0]),
        .src_b    (gr_rdata[1]),
        .nat_b    (gr_rnat[1]),
        .imm      (imm_i),
        .ld_data  (ld_data_i),
        .ld_fault (ld_fault_i),
        .gr_we    (ex_gr_we),
        .gr_wdata (ex_gr_wdata),
        .gr_wnat  (ex_gr_wnat),
        .pr_we    (ex_pr_we),
        .pr_val_a (ex_pa),
        .pr_val_b (ex_pb),
        .exc      (ex_exc),
        .redir    (ex_redir)
    );

    always_comb begin
        out_d        = out_q;
        out_d.exc    = ex_exc;
        out_d.redir  = ex_redir;
        if (ex_redir) out_d.target = imm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign exc_o             = out_q.exc;
    assign redirect_o        = out_q.redir;
    assign redirect_target_o = out_q.target;
    assign gr_peek_data_o    = gr_rdata[2];
    assign gr_peek_nat_o     = gr_rnat[2];
    assign pr_peek_val_o     = pr_rval[1];

endmodule

// File: rtl/pec_core_chk.sv
module pec_core_chk #(
    parameter int XLEN = 64,
    parameter int GW   = 7,
    parameter int PW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [3:0]      op,
    input logic [XLEN-1:0] imm,
    input logic            ld_fault,
    input logic            qp_true,
    input logic            exc,
    input logic            redirect,
    input logic [XLEN-1:0] target,
    input logic [GW-1:0]   gr_peek_addr,
    input logic [XLEN-1:0] gr_peek_data,
    input logic            gr_peek_nat,
    input logic [PW-1:0]   pr_peek_addr,
    input logic            pr_peek_val
);

    AST_PR0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_peek_addr == '0) |-> pr_peek_val); // R1

    AST_GR0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_peek_addr == '0) |-> (gr_peek_data == '0 && !gr_peek_nat)); // R1

    AST_QP_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !qp_true) |=> (!exc && !redirect)); // R2

    AST_EXC_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> ($past(instr_valid) && $past(op) == 4'd8 && $past(ld_fault))); // R7

    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ($past(instr_valid) && $past(op) == 4'd10 && target == $past(imm))); // R8

    AST_EXC_REDIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc && redirect)); // R8

endmodule

bind pred_exec_core pec_core_chk #(.XLEN(XLEN), .GW(GW), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid_i),
    .op           (op_i),
    .imm          (imm_i),
    .ld_fault     (ld_fault_i),
    .qp_true      (qp_true),
    .exc          (exc_o),
    .redirect     (redirect_o),
    .target       (redirect_target_o),
    .gr_peek_addr (gr_peek_addr_i),
    .gr_peek_data (gr_peek_data_o),
    .gr_peek_nat  (gr_peek_nat_o),
    .pr_peek_addr (pr_peek_addr_i),
    .pr_peek_val  (pr_peek_val_o)
);

// File: tb/pred_exec_core_tb.sv
module pred_exec_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [5:0]  qp_i = '0;
    logic [6:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
    logic [5:0]  pdst_a_i = '0, pdst_b_i = '0;
    logic [63:0] imm_i = '0, ld_data_i = '0;
    logic        ld_fault_i = 1'b0;
    logic        exc_o, redirect_o;
    logic [63:0] redirect_target_o;
    logic [6:0]  gr_peek_addr_i = '0;
    logic [63:0] gr_peek_data_o;
    logic        gr_peek_nat_o;
    logic [5:0]  pr_peek_addr_i = '0;
    logic        pr_peek_val_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_gr [128];
    logic        m_nat [128];
    logic        m_pr [64];

    always #10 clk = ~clk;

    pred_exec_core dut_i (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [5:0]  qp;
        logic [6:0]  rd;
        logic [6:0]  rs1;
        logic [6:0]  rs2;
        logic [5:0]  pa;
        logic [5:0]  pb;
        logic [15:0] imm;
        logic        flt;
        logic [15:0] ldd;
    } vec_t;

    // op qp rd rs1 rs2 pa pb imm flt ldd
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  6'd0, 7'd1, 7'd0, 7'd0, 6'd0, 6'd0, 16'h0,   1'b0, 16'h1234}, // R5
        '{4'd8,  6'd0, 7'd2, 7'd0, 7'd0, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0011}, // R5
        '{4'd1,  6'd0, 7'd3, 7'd1, 7'd2, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0},    // R4
        '{4'd7,  6'd0, 7'd0, 7'd1, 7'd2, 6'd1, 6'd2, 16'h0,   1'b0, 16'h0},    // R3
        '{4'd9,  6'd0, 7'd4, 7'd0, 7'd0, 6'd0, 6'd0, 16'h0,   1'b1, 16'hbeef}, // R6
        '{4'd1,  6'd0, 7'd5, 7'd4, 7'd1, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0},    // R4
        '{4'd10, 6'd0, 7'd0, 7'd5, 7'd0, 6'd0, 6'd0, 16'h0400, 1'b0, 16'h0},   // R8
        '{4'd10, 6'd0, 7'd0, 7'd3, 7'd0, 6'd0, 6'd0, 16'h0500, 1'b0, 16'h0},   // R8
        '{4'd8,  6'd0, 7'd3, 7'd0, 7'd0, 6'd0, 6'd0, 16'h0,   1'b1, 16'h5555}, // R7
        '{4'd1,  6'd2, 7'd1, 7'd3, 7'd3, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0},    // R2
        '{4'd2,  6'd1, 7'd6, 7'd1, 7'd2, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0},    // R4
        '{4'd5,  6'd0, 7'd0, 7'd1, 7'd0, 6'd0, 6'd0, 16'h5,   1'b0, 16'h0},    // R1
        '{4'd6,  6'd0, 7'd0, 7'd1, 7'd1, 6'd0, 6'd3, 16'h0,   1'b0, 16'h0},    // R1
        '{4'd7,  6'd0, 7'd0, 7'd5, 7'd1, 6'd4, 6'd5, 16'h0,   1'b0, 16'h0},    // R3
        '{4'd9,  6'd0, 7'd5, 7'd0, 7'd0, 6'd0, 6'd0, 16'h0,   1'b0, 16'h0077}, // R5
        '{4'd10, 6'd2, 7'd0, 7'd4, 7'd0, 6'd0, 6'd0, 16'h0600, 1'b0, 16'h0},   // R2
        '{4'd7,  6'd0, 7'd0, 7'd1, 7'd2, 6'd6, 6'd6, 16'h0,   1'b0, 16'h0}     // R3
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 128; i++) begin m_gr[i] = '0; m_nat[i] = 1'b0; end
        for (int i = 0; i < 64; i++) m_pr[i] = (i == 0);
    endtask

    task automatic gr_write(input logic [6:0] a, input logic [63:0] d, input logic n);
        if (a != 0) begin m_gr[a] = d; m_nat[a] = n; end
    endtask

    task automatic step(input logic [3:0] op, input logic [5:0] qp,
                        input logic [6:0] rd, input logic [6:0] rs1, input logic [6:0] rs2,
                        input logic [5:0] pa, input logic [5:0] pb,
                        input logic [63:0] imm, input logic flt, input logic [63:0] ldd);
        logic qpv, e_exc, e_red, cr;
        string req;
        qpv = m_pr[qp];
        e_exc = 1'b0;
        e_red = 1'b0;
        case (op)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5: req = "R4";
            4'd6, 4'd7: req = "R3";
            4'd8:       req = flt ? "R7" : "R5";
            4'd9:       req = flt ? "R6" : "R5";
            4'd10:      req = "R8";
            default:    req = "R8";
        endcase
        if (!qpv) req = "R2";
        else if (rd == 0 && op inside {[4'd1:4'd5], 4'd8, 4'd9}) req = "R1";
        if (qpv) begin
            case (op)
                4'd1: gr_write(rd, m_gr[rs1] + m_gr[rs2], m_nat[rs1] | m_nat[rs2]);
                4'd2: gr_write(rd, m_gr[rs1] - m_gr[rs2], m_nat[rs1] | m_nat[rs2]);
                4'd3: gr_write(rd, m_gr[rs1] & m_gr[rs2], m_nat[rs1] | m_nat[rs2]);
                4'd4: gr_write(rd, m_gr[rs1] ^ m_gr[rs2], m_nat[rs1] | m_nat[rs2]);
                4'd5: gr_write(rd, m_gr[rs1] + imm, m_nat[rs1]);
                4'd6, 4'd7: begin
                    cr = (op == 4'd6) ? (m_gr[rs1] == m_gr[rs2]) : (m_gr[rs1] != m_gr[rs2]);
                    if (m_nat[rs1] | m_nat[rs2]) begin
                        if (pb != 0) m_pr[pb] = 1'b0;
                        if (pa != 0) m_pr[pa] = 1'b0;
                    end else begin
                        if (pb != 0) m_pr[pb] = !cr;
                        if (pa != 0) m_pr[pa] = cr;
                    end
                end
                4'd8: if (flt) e_exc = 1'b1; else gr_write(rd, ldd, 1'b0);
                4'd9: if (flt) gr_write(rd, '0, 1'b1); else gr_write(rd, ldd, 1'b0);
                4'd10: e_red = m_nat[rs1];
                default: ;
            endcase
        end
        op_i = op; qp_i = qp; rd_i = rd; rs1_i = rs1; rs2_i = rs2;
        pdst_a_i = pa; pdst_b_i = pb; imm_i = imm; ld_fault_i = flt; ld_data_i = ldd;
        instr_valid_i = 1'b1;
        @(posedge clk);
        #1 instr_valid_i = 1'b0;
        check(req, "exc_o", 64'(exc_o), 64'(e_exc));
        check(req, "redirect_o", 64'(redirect_o), 64'(e_red));
        if (e_red) check(req, "redirect_target_o", redirect_target_o, imm);
        gr_peek_addr_i = rd;
        #1;
        check(req, "gr data", gr_peek_data_o, m_gr[rd]);
        check(req, "gr nat", 64'(gr_peek_nat_o), 64'(m_nat[rd]));
        pr_peek_addr_i = pa;
        #1 check(req, "pred a", 64'(pr_peek_val_o), 64'(m_pr[pa]));
        pr_peek_addr_i = pb;
        #1 check(req, "pred b", 64'(pr_peek_val_o), 64'(m_pr[pb]));
    endtask

    task automatic check_reset_state();
        // R9: cleared files and quiet outputs
        check("R9", "exc_o after reset", 64'(exc_o), 64'd0);
        check("R9", "redirect_o after reset", 64'(redirect_o), 64'd0);
        for (int i = 0; i < 8; i++) begin
            gr_peek_addr_i = 7'(i);
            pr_peek_addr_i = 6'(i);
            #1;
            check("R9", "gr data after reset", gr_peek_data_o, 64'd0);
            check("R9", "gr nat after reset", 64'(gr_peek_nat_o), 64'd0);
            check("R9", "pred after reset", 64'(pr_peek_val_o), 64'(i == 0));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid_i = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        model_reset();
        do_reset();
        check_reset_state();

        // directed table
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].qp, VEC[i].rd, VEC[i].rs1, VEC[i].rs2,
                 VEC[i].pa, VEC[i].pb, 64'(VEC[i].imm), VEC[i].flt, 64'(VEC[i].ldd));
        end

        // random stream over a small register window
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] rop;
            rop = ($urandom_range(0, 9) < 3) ? 4'($urandom_range(6, 7)) : 4'($urandom_range(0, 12));
            step(rop, 6'($urandom_range(0, 7)), 7'($urandom_range(0, 15)),
                 7'($urandom_range(0, 15)), 7'($urandom_range(0, 15)),
                 6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)),
                 {$urandom, $urandom}, ($urandom_range(0, 3) == 0),
                 64'($urandom_range(0, 3)));
        end

        // R1: direct writes to register 0 and predicate 0 are discarded
        step(4'd9, 6'd0, 7'd0, 7'd0, 7'd0, 6'd0, 6'd0, 64'd0, 1'b1, 64'd0);
        step(4'd6, 6'd0, 7'd0, 7'd0, 7'd1, 6'd0, 6'd0, 64'd0, 1'b0, 64'd0);

        // R9: reset in mid-run clears everything
        do_reset();
        check_reset_state();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule